// File: doc/BRIEF.md
# Two-Road Traffic Light Controller

This block sequences the lamps at a crossing of a north-south road and an east-west road. Only one road has right of way at any time. The road without right of way always shows red. A green phase lasts until the external `timer_i` strobe is seen high on a clock edge. The yellow phase that follows lasts exactly one clock. After it, right of way passes to the other road.

All six lamp drives are active-low, so a 0 lights the lamp. The lamps are a Moore decode of the registered phase, so they change only just after a rising clock edge. If the strobe is raised on the fourth green clock of each road, each road sees 4 clocks of green, 1 of yellow and 5 of red.

Top module: `traffic_light_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next phase is east-west green. After that edge, `ew_grn_n`=0 and `ns_red_n`=0, and the other four lamp outputs are 1.
- R2: In every cycle out of reset, exactly one of the three lamp outputs of each road is 0 (active-low, 0 = lit).
- R3: In east-west green with `timer_i`=0 at the edge, the controller stays in east-west green.
- R4: In east-west green with `timer_i`=1 at the edge, the next phase is east-west yellow: `ew_yel_n`=0 and `ns_red_n`=0.
- R5: East-west yellow always moves to north-south green (`ns_grn_n`=0, `ew_red_n`=0) after one clock, whatever the value of `timer_i`.
- R6: In north-south green, `timer_i`=0 holds the phase. `timer_i`=1 moves to north-south yellow (`ns_yel_n`=0, `ew_red_n`=0).
- R7: North-south yellow always moves to east-west green after one clock, whatever the value of `timer_i`.
- R8: In every cycle at least one road shows red, so both roads are never non-red at the same time.
- R9: When `timer_i` is pulsed on the fourth green clock of each road, each road shows 4 clocks green, then 1 yellow, then 5 red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_i | input | 1 | Ends the current green phase when high at an edge |
| ns_red_n | output | 1 | North-south red lamp, active-low |
| ns_yel_n | output | 1 | North-south yellow lamp, active-low |
| ns_grn_n | output | 1 | North-south green lamp, active-low |
| ew_red_n | output | 1 | East-west red lamp, active-low |
| ew_yel_n | output | 1 | East-west yellow lamp, active-low |
| ew_grn_n | output | 1 | East-west green lamp, active-low |

## Verification
The bound checker checks every cycle that each road lights one lamp and that one road is always red. It also checks every single-step move between phases, including the unconditional exit from yellow and the hold in green while the strobe is low. Only the bench's scenarios can show whole-cycle properties. These are the 4/1/5 lamp durations over a full rotation, a long hold in green, a strobe held high through yellow, and a reset taken in the middle of north-south green. Random strobe patterns are compared against a phase model computed in the bench.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_EW_GO   = 2'd0,
        PH_EW_WARN = 2'd1,
        PH_NS_GO   = 2'd2,
        PH_NS_WARN = 2'd3
    } phase_e;

    localparam phase_e PH_RESET = PH_EW_GO;

    typedef enum logic [1:0] {
        ASP_STOP = 2'd0,
        ASP_WARN = 2'd1,
        ASP_GO   = 2'd2
    } aspect_e;

    typedef struct packed {
        logic red_n;
        logic yel_n;
        logic grn_n;
    } lamps_t;

    typedef struct packed {
        aspect_e ns;
        aspect_e ew;
    } aspects_t;

    function automatic lamps_t aspect_to_lamps(aspect_e a);
        lamps_t l;
        l = '{red_n: 1'b1, yel_n: 1'b1, grn_n: 1'b1};
        unique case (a)
            ASP_GO:   l.grn_n = 1'b0;
            ASP_WARN: l.yel_n = 1'b0;
            default:  l.red_n = 1'b0;
        endcase
        return l;
    endfunction

    function automatic aspects_t phase_to_aspects(phase_e p);
        aspects_t a;
        unique case (p)
            PH_EW_GO:   a = '{ns: ASP_STOP, ew: ASP_GO};
            PH_EW_WARN: a = '{ns: ASP_STOP, ew: ASP_WARN};
            PH_NS_GO:   a = '{ns: ASP_GO,   ew: ASP_STOP};
            PH_NS_WARN: a = '{ns: ASP_WARN, ew: ASP_STOP};
            default:    a = '{ns: ASP_STOP, ew: ASP_GO};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tl_next_phase.sv
module tl_next_phase
    import tl_pkg::*;
(
    input  phase_e cur_i,
    input  logic   timer_i,
    output phase_e nxt_o
);
    always_comb begin
        unique case (cur_i)
            PH_EW_GO:   nxt_o = timer_i ? PH_EW_WARN : PH_EW_GO;
            PH_EW_WARN: nxt_o = PH_NS_GO;
            PH_NS_GO:   nxt_o = timer_i ? PH_NS_WARN : PH_NS_GO;
            PH_NS_WARN: nxt_o = PH_EW_GO;
            default:    nxt_o = PH_RESET;
        endcase
    end
endmodule

// File: rtl/tl_phase_reg.sv
module tl_phase_reg
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e nxt_i,
    output phase_e cur_o
);
    always_ff @(posedge clk) begin
        if (rst) cur_o <= PH_RESET;
        else     cur_o <= nxt_i;
    end
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  phase_e cur_i,
    output lamps_t ns_o,
    output lamps_t ew_o
);
    aspects_t asp;
    always_comb begin
        asp  = phase_to_aspects(cur_i);
        ns_o = aspect_to_lamps(asp.ns);
        ew_o = aspect_to_lamps(asp.ew);
    end
endmodule

// File: rtl/traffic_light_ctrl.sv
module traffic_light_ctrl
    import tl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic timer_i,
    output logic ns_red_n,
    output logic ns_yel_n,
    output logic ns_grn_n,
    output logic ew_red_n,
    output logic ew_yel_n,
    output logic ew_grn_n
);
    phase_e cur_q;
    phase_e nxt_d;
    lamps_t ns_l;
    lamps_t ew_l;

    tl_next_phase u_next (
        .cur_i  (cur_q),
        .timer_i(timer_i),
        .nxt_o  (nxt_d)
    );

    tl_phase_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .nxt_i(nxt_d),
        .cur_o(cur_q)
    );

    tl_lamp_decode u_dec (
        .cur_i(cur_q),
        .ns_o (ns_l),
        .ew_o (ew_l)
    );

    assign ns_red_n = ns_l.red_n;
    assign ns_yel_n = ns_l.yel_n;
    assign ns_grn_n = ns_l.grn_n;
    assign ew_red_n = ew_l.red_n;
    assign ew_yel_n = ew_l.yel_n;
    assign ew_grn_n = ew_l.grn_n;
endmodule

// File: rtl/traffic_light_checker.sv
module traffic_light_checker (
    input logic clk,
    input logic rst,
    input logic timer_i,
    input logic ns_red_n,
    input logic ns_yel_n,
    input logic ns_grn_n,
    input logic ew_red_n,
    input logic ew_yel_n,
    input logic ew_grn_n
);
    logic ew_go, ew_warn, ns_go, ns_warn;
    assign ew_go   = !ew_grn_n && !ns_red_n;
    assign ew_warn = !ew_yel_n && !ns_red_n;
    assign ns_go   = !ns_grn_n && !ew_red_n;
    assign ns_warn = !ns_yel_n && !ew_red_n;

    p_reset_r1: assert property (@(posedge clk) rst |=> ew_go && ns_yel_n && ns_grn_n && ew_red_n && ew_yel_n);
    p_one_lamp_ns_r2: assert property (@(posedge clk) disable iff (rst) $countones({ns_red_n, ns_yel_n, ns_grn_n}) == 2);
    p_one_lamp_ew_r2: assert property (@(posedge clk) disable iff (rst) $countones({ew_red_n, ew_yel_n, ew_grn_n}) == 2);
    p_ew_hold_r3: assert property (@(posedge clk) disable iff (rst) ew_go && !timer_i |=> ew_go);
    p_ew_to_yel_r4: assert property (@(posedge clk) disable iff (rst) ew_go && timer_i |=> ew_warn);
    p_yel_to_ns_r5: assert property (@(posedge clk) disable iff (rst) ew_warn |=> ns_go);
    p_ns_hold_r6: assert property (@(posedge clk) disable iff (rst) ns_go && !timer_i |=> ns_go);
    p_ns_to_yel_r6: assert property (@(posedge clk) disable iff (rst) ns_go && timer_i |=> ns_warn);
    p_yel_to_ew_r7: assert property (@(posedge clk) disable iff (rst) ns_warn |=> ew_go);
    p_one_red_r8: assert property (@(posedge clk) disable iff (rst) !ns_red_n || !ew_red_n);
endmodule

bind traffic_light_ctrl traffic_light_checker u_chk (
    .clk(clk), .rst(rst), .timer_i(timer_i),
    .ns_red_n(ns_red_n), .ns_yel_n(ns_yel_n), .ns_grn_n(ns_grn_n),
    .ew_red_n(ew_red_n), .ew_yel_n(ew_yel_n), .ew_grn_n(ew_grn_n)
);

// File: tb/tb_traffic_light_ctrl.sv
module tb_traffic_light_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic timer_i = 1'b0;
    logic ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n;
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench phase codes: 0 EW green, 1 EW yellow, 2 NS green, 3 NS yellow
    int exp_ph;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    traffic_light_ctrl dut (
        .clk(clk), .rst(rst), .timer_i(timer_i),
        .ns_red_n(ns_red_n), .ns_yel_n(ns_yel_n), .ns_grn_n(ns_grn_n),
        .ew_red_n(ew_red_n), .ew_yel_n(ew_yel_n), .ew_grn_n(ew_grn_n)
    );

    function automatic int model_next(int ph, bit t);
        case (ph)
            0: return t ? 1 : 0;
            1: return 2;
            2: return t ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    // {ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n}
    function automatic logic [5:0] model_lamps(int ph);
        case (ph)
            0: return 6'b011_110;
            1: return 6'b011_101;
            2: return 6'b110_011;
            default: return 6'b101_011;
        endcase
    endfunction

    function automatic logic [5:0] got();
        return {ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one modelled cycle: drive t at negedge, step the model, compare after the edge
    task automatic step(bit t, string req);
        timer_i = t;
        exp_ph = model_next(exp_ph, t);
        @(negedge clk);
        check(req, got(), model_lamps(exp_ph));
    endtask

    task automatic do_reset();
        rst = 1'b1; timer_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_ph = 0;
    endtask

    initial begin
        int ewg, ewy, ewr, nsg, nsy, nsr;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        do_reset();
        check("R1 reset lamps", got(), 6'b011_110);

        // R3: long hold with timer low
        for (int i = 0; i < 30; i++) step(1'b0, "R3 hold EW green");

        // R9: full rotation with strobe on fourth green clock, count lamp durations
        do_reset();
        ewg = 0; ewy = 0; ewr = 0; nsg = 0; nsy = 0; nsr = 0;
        for (int i = 0; i < 10; i++) begin
            // current observed cycle belongs to window; strobe on 4th green clock of each road
            if (!ew_grn_n) ewg++;
            if (!ew_yel_n) ewy++;
            if (!ew_red_n) ewr++;
            if (!ns_grn_n) nsg++;
            if (!ns_yel_n) nsy++;
            if (!ns_red_n) nsr++;
            if (i == 9) begin
                timer_i = 1'b0;
            end else begin
                step((i == 3) || (i == 8), "R9 rotation step");
            end
        end
        check("R9 EW green clocks", ewg, 4);
        check("R9 EW yellow clocks", ewy, 1);
        check("R9 EW red clocks", ewr, 5);
        check("R9 NS green clocks", nsg, 4);
        check("R9 NS yellow clocks", nsy, 1);
        check("R9 NS red clocks", nsr, 5);
        step(1'b0, "R7 back to EW green after rotation");

        // R4/R5/R6/R7: strobe held high through yellow has no effect
        step(1'b1, "R4 EW green to yellow");
        step(1'b1, "R5 yellow to NS green with timer high");
        step(1'b0, "R6 NS hold");
        step(1'b1, "R6 NS green to yellow");
        step(1'b1, "R7 NS yellow to EW green with timer high");

        // R1: reset in the middle of NS green
        step(1'b1, "R4 EW to yellow");
        step(1'b0, "R5 to NS green");
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset from NS green", got(), 6'b011_110);
        rst = 1'b0; exp_ph = 0;

        // random strobe patterns, R2/R8 checked on every cycle
        for (int i = 0; i < 3000; i++) begin
            bit t;
            t = ($urandom % 3) == 0;
            step(t, "R2/R8 random sequence");
            checks++;
            if (($countones(got() [5:3]) != 2) || ($countones(got() [2:0]) != 2)
                || (ns_red_n && ew_red_n)) begin
                failures++;
                $display("FAIL R2/R8 actual=%0h expected one lamp per road and one red", got());
            end
        end
        done = 1'b1;
    end

    initial begin
        wait (done || cyc > 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule